// File: doc/BRIEF.md
# Biphase Missing-Clock Monitor

This block supervises the clock content of a biphase (FM) encoded serial line. A digital PLL timing generator outside the block marks the end of each interval in which a line transition is due. A synchronizer reports every transition it sees. When an interval closes with no transition, the monitor raises a sticky "one missing" flag. When two intervals in a row close empty, it also raises a sticky "two missing" flag. At that moment it sends a one-cycle request that tells the PLL to fall back to acquisition (search) mode.

After that request the monitor stops judging intervals until the PLL reports lock again. Both flags stay set until the command side issues a clear-missing command or an enter-search command. Both flags read as zero whenever the PLL is disabled or the line is NRZI coded. In those states the stored flags and the miss count are discarded.

The result is an 8-bit read-only status byte. Bit 7 is the one-missing flag and bit 6 is the two-missing flag. Bits 4 and 1 carry two loop-mode indications, which enter the block from outside. Every other bit reads 0.

Top module: `fm_clk_monitor`

## Requirements
- R1: With `pll_en`=1 and `fm_sel`=1, a `win_close` strobe sets status bit 7 from the next clock edge onward if no `edge_seen` pulse arrived since the previous strobe. An edge in the same cycle as the strobe counts for the closing interval.
- R2: An interval that closes with an edge does not set either flag and returns the consecutive-miss count to zero. A miss that follows such an interval is therefore a first miss.
- R3: The second consecutive empty interval sets status bit 6 together with bit 7. The miss count then restarts at zero.
- R4: `search_req` is high for exactly one cycle. It rises on the same clock edge on which bit 6 is set by R3.
- R5: Bits 7 and 6 stay set until `cmd_clr_miss` or `cmd_search` is high at a clock edge. Either command clears both flags and the miss count at that edge.
- R6: If a clear command and a miss occur at the same edge, bit 7 stays set and bit 6 clears. The miss counts as the first of a new run, so one further miss sets bit 6.
- R7: After a search request, `win_close` strobes are ignored until `pll_locked` is sampled high. No flag changes and no request is issued in that time.
- R8: While `pll_en`=0 or `fm_sel`=0 (NRZI), bits 7 and 6 read 0 at once. Flags, miss count and the lock wait are discarded at the next edge, so re-entering FM mode starts clean.
- R9: Status bit 4 follows `loop_sending` and bit 1 follows `on_loop` combinationally. Bits 5, 3, 2 and 0 are always 0.
- R10: While `rst_n` is sampled low, both flags clear and `search_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_en | input | 1 | PLL enabled |
| fm_sel | input | 1 | 1 = biphase (FM) coding, 0 = NRZI |
| win_close | input | 1 | One-cycle strobe ending an expected-edge interval |
| edge_seen | input | 1 | One-cycle pulse per synchronized line transition |
| pll_locked | input | 1 | PLL reports lock after a search |
| cmd_clr_miss | input | 1 | Reset-missing-clock command pulse |
| cmd_search | input | 1 | Enter-search-mode command pulse |
| loop_sending | input | 1 | Loop transmit-in-control indication |
| on_loop | input | 1 | On-loop indication |
| status_o | output | 8 | Status byte |
| search_req | output | 1 | One-cycle request that puts the PLL into search mode |

## Verification
Flag and request results are registered. They become due on the first rising edge that samples the causing strobe or command, so the bench compares them 2 ns after that edge. The combinational results appear within the same cycle as the input change: gating of bits 7 and 6 by mode, and the loop bits. The bench checks these before the next edge. A behavioural model in the bench updates on each rising edge from the same sampled inputs, and the whole status byte and the request are compared after every edge. Directed checks pin down the same-edge clear-and-miss case, the one-cycle width of the request, and the lock wait.

// File: rtl/fm_mon_pkg.sv
// Shared constants and types for the biphase missing-clock monitor.
// Assumes an 8-bit status byte whose flag positions are fixed by the
// register decoder that reads it.
package fm_mon_pkg;
    localparam int STATUS_W     = 8;
    localparam int BIT_MISS_ONE = 7;
    localparam int BIT_MISS_TWO = 6;
    localparam int BIT_LOOP_TX  = 4;
    localparam int BIT_ON_LOOP  = 1;

    typedef struct packed {
        logic miss_one;
        logic miss_two;
    } miss_flags_t;
endpackage

// File: rtl/fm_edge_window.sv
// Tracks whether a line transition arrived inside the current expected-edge
// interval and classifies each interval at its closing strobe.
// Assumes win_close and edge_seen are single-cycle, synchronous pulses.
module fm_edge_window (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic edge_seen,
    input  logic win_close,
    output logic win_hit,
    output logic win_miss
);
    logic seen_q;
    logic got_edge;

    // Remember an edge until the interval closes or monitoring stops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (!active || win_close)
            seen_q <= 1'b0;
        else if (edge_seen)
            seen_q <= 1'b1;
    end

    // An edge in the closing cycle still belongs to the closing interval.
    always_comb begin
        got_edge = seen_q | edge_seen;
        win_hit  = active & win_close & got_edge;
        win_miss = active & win_close & ~got_edge;
    end

    // R2
    interval_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && edge_seen && !win_close) |=> (!win_close || win_hit || !active));
endmodule

// File: rtl/fm_miss_tracker.sv
// Counts consecutive empty intervals, holds the sticky missing-clock flags,
// issues the one-cycle search request and waits for relock.
// Assumes win_hit/win_miss are mutually exclusive and already mode-qualified.
module fm_miss_tracker
    import fm_mon_pkg::*;
#(
    parameter int MISS_LIMIT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active,
    input  logic        win_hit,
    input  logic        win_miss,
    input  logic        clr_cmd,
    input  logic        pll_locked,
    output miss_flags_t flags,
    output logic        search_req
);
    localparam int CNT_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MISS_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_base;
    logic             hold_q;
    logic             miss_ok;
    logic             hit_ok;
    logic             last_miss;
    miss_flags_t      flags_q;
    logic             search_q;

    // Qualify interval results by the relock wait; a clear restarts the run.
    always_comb begin
        miss_ok   = win_miss & ~hold_q;
        hit_ok    = win_hit & ~hold_q;
        cnt_base  = clr_cmd ? '0 : cnt_q;
        last_miss = miss_ok & (cnt_base == LAST_CNT);
    end

    // Consecutive-miss counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            cnt_q <= '0;
        else if (last_miss)
            cnt_q <= '0;
        else if (miss_ok)
            cnt_q <= cnt_base + CNT_W'(1);
        else if (hit_ok || clr_cmd)
            cnt_q <= '0;
    end

    // Sticky flags: a new miss outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            flags_q <= '0;
        end else begin
            if (miss_ok)
                flags_q.miss_one <= 1'b1;
            else if (clr_cmd)
                flags_q.miss_one <= 1'b0;
            if (last_miss)
                flags_q.miss_two <= 1'b1;
            else if (clr_cmd)
                flags_q.miss_two <= 1'b0;
        end
    end

    // One-cycle search request on the final miss of a run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            search_q <= 1'b0;
        else
            search_q <= active & last_miss;
    end

    // Ignore intervals from the search request until lock returns.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            hold_q <= 1'b0;
        else if (last_miss)
            hold_q <= 1'b1;
        else if (pll_locked)
            hold_q <= 1'b0;
    end

    assign flags      = flags_q;
    assign search_req = search_q;

    // R4
    search_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        search_req |=> !search_req);
    // R3
    search_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        search_req |-> (flags.miss_two && flags.miss_one));
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && flags.miss_one && !clr_cmd) |=> flags.miss_one);
    // R7
    relock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !pll_locked && active && !clr_cmd) |=> $stable(flags));
    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MISS_LIMIT));
endmodule

// File: rtl/fm_status_pack.sv
// Assembles the read-only status byte from the flags and the loop inputs.
// Assumes the flag positions in fm_mon_pkg match the register decoder.
module fm_status_pack
    import fm_mon_pkg::*;
(
    input  miss_flags_t         flags,
    input  logic                active,
    input  logic                loop_sending,
    input  logic                on_loop,
    output logic [STATUS_W-1:0] status
);
    for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
        if (b == BIT_MISS_ONE) begin : g_one
            assign status[b] = flags.miss_one & active;
        end else if (b == BIT_MISS_TWO) begin : g_two
            assign status[b] = flags.miss_two & active;
        end else if (b == BIT_LOOP_TX) begin : g_ltx
            assign status[b] = loop_sending;
        end else if (b == BIT_ON_LOOP) begin : g_onl
            assign status[b] = on_loop;
        end else begin : g_zero
            assign status[b] = 1'b0;
        end
    end
endmodule

// File: rtl/fm_clk_monitor.sv
// Top of the biphase missing-clock monitor: mode gating, interval checking,
// miss tracking and status byte. Assumes all inputs are synchronous to clk.
module fm_clk_monitor
    import fm_mon_pkg::*;
#(
    parameter int MISS_LIMIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pll_en,
    input  logic                fm_sel,
    input  logic                win_close,
    input  logic                edge_seen,
    input  logic                pll_locked,
    input  logic                cmd_clr_miss,
    input  logic                cmd_search,
    input  logic                loop_sending,
    input  logic                on_loop,
    output logic [STATUS_W-1:0] status_o,
    output logic                search_req
);
    logic        active;
    logic        clr_cmd;
    logic        win_hit;
    logic        win_miss;
    miss_flags_t flags;

    // Monitoring only runs with the PLL on and biphase coding selected.
    always_comb begin
        active  = pll_en & fm_sel;
        clr_cmd = cmd_clr_miss | cmd_search;
    end

    fm_edge_window u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .edge_seen (edge_seen),
        .win_close (win_close),
        .win_hit   (win_hit),
        .win_miss  (win_miss)
    );

    fm_miss_tracker #(.MISS_LIMIT(MISS_LIMIT)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .win_hit    (win_hit),
        .win_miss   (win_miss),
        .clr_cmd    (clr_cmd),
        .pll_locked (pll_locked),
        .flags      (flags),
        .search_req (search_req)
    );

    fm_status_pack u_pack (
        .flags        (flags),
        .active       (active),
        .loop_sending (loop_sending),
        .on_loop      (on_loop),
        .status       (status_o)
    );

    // R8
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_en && fm_sel) |-> (status_o[BIT_MISS_ONE] == 1'b0 && status_o[BIT_MISS_TWO] == 1'b0));
    // R1
    miss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_miss && (pll_en && fm_sel) && !search_req && $past(rst_n) && !$past(search_req)
         && u_trk.hold_q == 1'b0) |=> (!(pll_en && fm_sel) || status_o[BIT_MISS_ONE]));
endmodule

// File: tb/tb_fm_clk_monitor.sv
module tb_fm_clk_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_en = 1'b0, fm_sel = 1'b0, win_close = 1'b0, edge_seen = 1'b0;
    logic       pll_locked = 1'b0, cmd_clr_miss = 1'b0, cmd_search = 1'b0;
    logic       loop_sending = 1'b0, on_loop = 1'b0;
    logic [7:0] status_o;
    logic       search_req;

    localparam int LIMIT = 2;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R10";

    // reference model state
    int m_cnt = 0;
    bit m_f1 = 0, m_f2 = 0, m_hold = 0, m_srq = 0, m_seen = 0;

    always #4 clk = ~clk;

    fm_clk_monitor #(.MISS_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .fm_sel(fm_sel),
        .win_close(win_close), .edge_seen(edge_seen), .pll_locked(pll_locked),
        .cmd_clr_miss(cmd_clr_miss), .cmd_search(cmd_search),
        .loop_sending(loop_sending), .on_loop(on_loop),
        .status_o(status_o), .search_req(search_req)
    );

    // Behavioural model, advanced on each rising edge from sampled inputs.
    always @(posedge clk) begin
        bit act, got, miss, hit, fire;
        act = pll_en && fm_sel;
        got = m_seen || edge_seen;
        if (!rst_n) begin
            m_cnt = 0; m_f1 = 0; m_f2 = 0; m_hold = 0; m_srq = 0; m_seen = 0;
        end else if (!act) begin
            m_cnt = 0; m_f1 = 0; m_f2 = 0; m_hold = 0; m_srq = 0; m_seen = 0;
        end else begin
            miss = win_close && !got && !m_hold;
            hit  = win_close && got && !m_hold;
            fire = 0;
            if (cmd_clr_miss || cmd_search) begin m_cnt = 0; m_f1 = 0; m_f2 = 0; end
            if (hit) m_cnt = 0;
            if (miss) begin
                m_f1 = 1;
                m_cnt = m_cnt + 1;
                if (m_cnt >= LIMIT) begin m_f2 = 1; m_cnt = 0; fire = 1; end
            end
            if (fire) m_hold = 1; else if (pll_locked) m_hold = 0;
            m_srq = fire;
            m_seen = win_close ? 0 : got;
        end
    end

    function automatic logic [7:0] exp_status();
        bit act;
        act = pll_en && fm_sel;
        return {m_f1 && act, m_f2 && act, 1'b0, loop_sending, 2'b00, on_loop, 1'b0};
    endfunction

    task automatic chk(input string t, input logic [8:0] got, input logic [8:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
        end
    endtask

    // One clock: model and design advance, then compare 2 ns after the edge.
    task automatic step();
        @(posedge clk);
        #2;
        chk(tag, {search_req, status_o}, {m_srq, exp_status()});
        win_close = 0; edge_seen = 0; cmd_clr_miss = 0; cmd_search = 0;
    endtask

    task automatic window(input bit with_edge);
        edge_seen = with_edge; step();
        win_close = 1; step();
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1;
        // R10 reset state
        tag = "R10";
        repeat (3) step();
        chk("R10", {search_req, status_o}, 9'h000);
        rst_n = 1;
        step();

        // R9 loop bits pass through, spare bits zero
        tag = "R9";
        loop_sending = 1; #1;
        chk("R9", {1'b0, status_o}, 9'h010);
        on_loop = 1; #1;
        chk("R9", {1'b0, status_o}, 9'h012);
        step();
        loop_sending = 0; on_loop = 0; step();

        pll_en = 1; fm_sel = 1; pll_locked = 1;
        step();

        // R2 windows with edges raise nothing
        tag = "R2";
        for (int i = 0; i < 3; i++) window(1);
        chk("R2", {1'b0, status_o[7:6]}, 9'h000);

        // R1 empty window sets bit 7 (edge in closing cycle counts as hit first)
        tag = "R1";
        edge_seen = 1; win_close = 1; step();
        chk("R1", {8'h0, status_o[7]}, 9'h0);
        window(0);
        chk("R1", {8'h0, status_o[7]}, 9'h1);

        // R2 a hit breaks the run
        tag = "R2";
        window(1);
        window(0);
        chk("R2", {8'h0, status_o[6]}, 9'h0);

        // R3 R4 second consecutive miss
        tag = "R3";
        pll_locked = 0;
        edge_seen = 0; step();
        win_close = 1; step();
        chk("R3", {8'h0, status_o[6]}, 9'h1);
        chk("R4", {8'h0, search_req}, 9'h1);
        step();
        chk("R4", {8'h0, search_req}, 9'h0);

        // R7 windows ignored while awaiting lock (clear first, then look)
        tag = "R7";
        cmd_clr_miss = 1; step();
        for (int i = 0; i < 4; i++) window(0);
        chk("R7", {search_req, status_o}, 9'h000);
        pll_locked = 1; step();
        window(0);
        chk("R7", {8'h0, status_o[7]}, 9'h1);

        // R5 sticky, cleared by either command
        tag = "R5";
        repeat (5) step();
        chk("R5", {8'h0, status_o[7]}, 9'h1);
        cmd_clr_miss = 1; step();
        chk("R5", {1'b0, status_o}, 9'h000);
        window(0); window(0);
        chk("R5", {1'b0, status_o[7:6], 6'h0}, 9'h0C0);
        cmd_search = 1; step();
        chk("R5", {1'b0, status_o}, 9'h000);

        // R6 clear and miss at the same edge
        tag = "R6";
        window(0);
        step();
        win_close = 1; cmd_clr_miss = 1; step();
        chk("R6", {1'b0, status_o[7:6], 6'h0}, 9'h080);
        window(0);
        chk("R6", {1'b0, status_o[7:6], 6'h0}, 9'h0C0);

        // R8 NRZI and disabled gating
        tag = "R8";
        fm_sel = 0; #1;
        chk("R8", {8'h0, status_o[7] | status_o[6]}, 9'h0);
        step();
        fm_sel = 1; step();
        chk("R8", {1'b0, status_o}, 9'h000);
        window(0);
        chk("R8", {1'b0, status_o[7:6], 6'h0}, 9'h080);
        pll_en = 0; #1;
        chk("R8", {8'h0, status_o[7] | status_o[6]}, 9'h0);
        step();
        pll_en = 1; step();
        window(0);
        chk("R8", {1'b0, status_o[7:6], 6'h0}, 9'h080);

        // R1 R3 mixed traffic against the model
        tag = "R3";
        for (int i = 0; i < 2000; i++) begin
            edge_seen    = ($urandom_range(0, 3) == 0);
            win_close    = ($urandom_range(0, 3) == 0);
            pll_locked   = ($urandom_range(0, 3) != 0);
            cmd_clr_miss = ($urandom_range(0, 29) == 0);
            cmd_search   = ($urandom_range(0, 39) == 0);
            fm_sel       = ($urandom_range(0, 49) != 0);
            pll_en       = ($urandom_range(0, 59) != 0);
            loop_sending = $urandom_range(0, 1);
            on_loop      = $urandom_range(0, 1);
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule